// File: doc/BRIEF.md
# Back-Bias Frequency-Lock Controller

This block is the digital half of a body-bias regulator. It holds a core's ring-oscillator clock at a target rate by sending step commands to two well-bias current drivers, one for the n-well and one for the p-well. The target clock and the oscillator clock come in as free-running asynchronous signals. Both are synchronised into the controller clock, and the controller counts rising edges on them. A measurement window spans `cfg_r_i` target-clock periods. The number of oscillator edges in that window is compared against the internal ratio N, so lock means f_target / R = f_osc / N.

The controller starts in a coarse phase, where only this frequency comparison is active. After a run of windows close to N it enters a fine phase. In the fine phase, up/down events from on-die timing monitors also move N by one step per window, inside programmable bounds. This shifts the lock point as voltage and temperature drift, and the bias loop then follows the new N. Each driver has a saturating bias code, and the controller emits one step pulse per window decision.

Top module: `abb_lock_ctrl`

## Requirements
- R1: While reset is asserted, and after its release before the first window closes, both bias codes equal the zero-bias code 32, the fine flag and the locked flag are 0, the drop counter is 0 and no step pulse is issued. From the second cycle after release, N equals `cfg_n_init_i`.
- R2: A window closes after `cfg_r_i` rising edges of the target clock, and each window is one adjust decision. If the oscillator edge count is below N, the decision is one increment pulse. If the count is above N, it is one decrement pulse. If the count equals N, there is no pulse.
- R3: Every decision pulse lasts one cycle and appears on both drivers in the same cycle with the same direction. Each increment raises that driver's 6-bit code by 1, and each decrement lowers it by 1.
- R4: Codes stay within 0..63. A pulse that would step a code beyond either end is not issued.
- R5: The coarse phase moves to the fine phase (`fine_o`=1) at the end of the fourth consecutive window whose count is within ±1 of N.
- R6: `locked_o` is 1 only in the fine phase, and only when the most recent window's count was within ±1 of N.
- R7: The fine phase returns to coarse, clearing `fine_o` and `locked_o`, at the end of the fourth consecutive window whose count differs from N by more than 4. Smaller errors never end the fine phase.
- R8: Monitor events arriving in the coarse phase leave N unchanged.
- R9: In the fine phase, a window that contains any monitor up event and no down event raises N by 1 when the window closes. A window with only down events lowers N by 1.
- R10: A window that contains both up and down monitor events leaves N unchanged.
- R11: N stays between `cfg_n_min_i` and `cfg_n_max_i`. A monitor step that would cross a bound is dropped, and `drop_cnt_o` then increases by 1. This counter saturates and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_i | input | 1 | Target-frequency clock, asynchronous |
| osc_clk_i | input | 1 | Core ring-oscillator clock, asynchronous |
| mon_up_i | input | NMON | Timing-monitor requests to raise N, synchronous to clk |
| mon_dn_i | input | NMON | Timing-monitor requests to lower N, synchronous to clk |
| cfg_r_i | input | R_W | Target-clock periods per window (R) |
| cfg_n_init_i | input | N_W | Value N takes after reset |
| cfg_n_min_i | input | N_W | Lower bound on N |
| cfg_n_max_i | input | N_W | Upper bound on N |
| nw_inc_o | output | 1 | n-well driver increment pulse |
| nw_dec_o | output | 1 | n-well driver decrement pulse |
| pw_inc_o | output | 1 | p-well driver increment pulse |
| pw_dec_o | output | 1 | p-well driver decrement pulse |
| nw_code_o | output | CODE_W | n-well bias code |
| pw_code_o | output | CODE_W | p-well bias code |
| fine_o | output | 1 | Fine (monitor-driven) phase active |
| locked_o | output | 1 | Last window within ±1 of N while in the fine phase |
| n_cur_o | output | N_W | Current internal ratio N |
| drop_cnt_o | output | DROP_W | Sticky count of monitor steps dropped at a bound |

## Verification
An off-by-one in the window counter shows up as a changed edge count within one window. The bench sees this as stray step pulses once the count should equal N, and as a wrong pulse total over a known span. A wrong run counter for lock or unlock moves `fine_o` one window early or late, so the phase flag is checked just before and just after the fourth qualifying window. A broken N trim or bound shows on `n_cur_o` and `drop_cnt_o` within two windows of a single monitor pulse.

// File: rtl/abb_pkg.sv
`timescale 1ns/1ps
package abb_pkg;
  typedef enum logic {
    PH_COARSE = 1'b0,
    PH_FINE   = 1'b1
  } abb_phase_e;
endpackage

// File: rtl/abb_rst_sync.sv
`timescale 1ns/1ps
module abb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/abb_edge_sync.sv
`timescale 1ns/1ps
module abb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/abb_freq_meter.sv
`timescale 1ns/1ps
module abb_freq_meter #(
  parameter int R_W   = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise_i,
  input  logic             osc_rise_i,
  input  logic [R_W-1:0]   cfg_r_i,
  output logic             win_end_o,
  output logic [CNT_W-1:0] win_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [R_W-1:0]   ref_cnt_q, ref_cnt_d;
  logic [CNT_W-1:0] osc_cnt_q, osc_cnt_d, osc_sum;
  logic             win_end_q, win_end_d;
  logic [CNT_W-1:0] win_cnt_q, win_cnt_d;
  logic [R_W:0]     ref_nxt;
  logic             last;

  always_comb begin
    ref_nxt = {1'b0, ref_cnt_q} + {{R_W{1'b0}}, 1'b1};
    last    = ref_rise_i && (ref_nxt >= {1'b0, cfg_r_i});
    osc_sum = (osc_cnt_q == CNT_MAX) ? CNT_MAX
                                     : osc_cnt_q + {{(CNT_W-1){1'b0}}, osc_rise_i};
    ref_cnt_d = ref_cnt_q;
    if (ref_rise_i) ref_cnt_d = last ? '0 : ref_nxt[R_W-1:0];
    osc_cnt_d = last ? '0 : osc_sum;
    win_end_d = last;
    win_cnt_d = last ? osc_sum : win_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      osc_cnt_q <= '0;
      win_end_q <= 1'b0;
      win_cnt_q <= '0;
    end else begin
      ref_cnt_q <= ref_cnt_d;
      osc_cnt_q <= osc_cnt_d;
      win_end_q <= win_end_d;
      win_cnt_q <= win_cnt_d;
    end
  end

  assign win_end_o = win_end_q;
  assign win_cnt_o = win_cnt_q;

  assert_one_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_q |=> !win_end_q);
endmodule

// File: rtl/abb_bias_code.sv
`timescale 1ns/1ps
module abb_bias_code #(
  parameter int CODE_W    = 6,
  parameter int ZERO_CODE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_i,
  input  logic              dn_req_i,
  output logic              inc_o,
  output logic              dec_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_ZERO = CODE_W'(ZERO_CODE);

  logic [CODE_W-1:0] code_q, code_d;
  logic              step_en;

  always_comb begin
    inc_o   = up_req_i && !dn_req_i && (code_q != CODE_MAX);
    dec_o   = dn_req_i && !up_req_i && (code_q != '0);
    step_en = inc_o || dec_o;
    code_d  = code_q;
    if (inc_o)      code_d = code_q + {{(CODE_W-1){1'b0}}, 1'b1};
    else if (dec_o) code_d = code_q - {{(CODE_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CODE_ZERO;
    else if (step_en) code_q <= code_d;
  end

  assign code_o = code_q;

  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |=> code_q == $past(code_q) + 1'b1);
  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_o |=> code_q == $past(code_q) - 1'b1);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_o || dec_o) |=> !(inc_o || dec_o));
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MAX) |=> code_q != '0);
endmodule

// File: rtl/abb_trim_ctrl.sv
`timescale 1ns/1ps
module abb_trim_ctrl
  import abb_pkg::*;
#(
  parameter int N_W        = 8,
  parameter int CNT_W      = 9,
  parameter int DROP_W     = 8,
  parameter int LOCK_WIN   = 4,
  parameter int UNLOCK_WIN = 4,
  parameter int LOCK_TOL   = 1,
  parameter int UNLOCK_TOL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_end_i,
  input  logic [CNT_W-1:0]  win_cnt_i,
  input  logic              mon_up_i,
  input  logic              mon_dn_i,
  input  logic [N_W-1:0]    cfg_n_init_i,
  input  logic [N_W-1:0]    cfg_n_min_i,
  input  logic [N_W-1:0]    cfg_n_max_i,
  output logic              up_req_o,
  output logic              dn_req_o,
  output logic              fine_o,
  output logic              locked_o,
  output logic [N_W-1:0]    n_o,
  output logic [DROP_W-1:0] drop_o
);
  localparam int SW    = CNT_W + 1;
  localparam int RUN_W = $clog2(((LOCK_WIN > UNLOCK_WIN) ? LOCK_WIN : UNLOCK_WIN) + 1);
  localparam logic [RUN_W-1:0] LOCK_LAST   = RUN_W'(LOCK_WIN - 1);
  localparam logic [RUN_W-1:0] UNLOCK_LAST = RUN_W'(UNLOCK_WIN - 1);

  abb_phase_e         phase_q, phase_d;
  logic [N_W-1:0]     n_q, n_d;
  logic [DROP_W-1:0]  drop_q, drop_d;
  logic [RUN_W-1:0]   good_q, good_d, bad_q, bad_d;
  logic               up_q, up_d, dn_q, dn_d;
  logic               lock_q, lock_d;
  logic               useen_q, useen_d, dseen_q, dseen_d;
  logic               started_q;
  logic signed [SW-1:0] diff;
  logic [SW-1:0]      mag;
  logic               good, bad, up_any, dn_any, drop_hit;

  always_comb begin
    diff = $signed({1'b0, win_cnt_i}) - $signed({{(SW-N_W){1'b0}}, n_q});
    mag  = diff[SW-1] ? SW'(-diff) : SW'(diff);
    good = mag <= SW'(LOCK_TOL);
    bad  = mag >  SW'(UNLOCK_TOL);
    up_any = (phase_q == PH_FINE) && (useen_q || mon_up_i);
    dn_any = (phase_q == PH_FINE) && (dseen_q || mon_dn_i);

    phase_d  = phase_q;
    n_d      = started_q ? n_q : cfg_n_init_i;
    good_d   = good_q;
    bad_d    = bad_q;
    lock_d   = lock_q;
    up_d     = 1'b0;
    dn_d     = 1'b0;
    useen_d  = up_any;
    dseen_d  = dn_any;
    drop_hit = 1'b0;

    if (win_end_i) begin
      up_d    = diff[SW-1];
      dn_d    = !diff[SW-1] && (diff != '0);
      useen_d = 1'b0;
      dseen_d = 1'b0;
      if (phase_q == PH_FINE) begin
        if (up_any && !dn_any) begin
          if (n_q < cfg_n_max_i) n_d = n_q + {{(N_W-1){1'b0}}, 1'b1};
          else                   drop_hit = 1'b1;
        end else if (dn_any && !up_any) begin
          if (n_q > cfg_n_min_i) n_d = n_q - {{(N_W-1){1'b0}}, 1'b1};
          else                   drop_hit = 1'b1;
        end
        lock_d = good;
        if (bad) begin
          if (bad_q == UNLOCK_LAST) begin
            phase_d = PH_COARSE;
            bad_d   = '0;
            good_d  = '0;
            lock_d  = 1'b0;
          end else begin
            bad_d = bad_q + 1'b1;
          end
        end else begin
          bad_d = '0;
        end
      end else begin
        if (good) begin
          if (good_q == LOCK_LAST) begin
            phase_d = PH_FINE;
            good_d  = '0;
            bad_d   = '0;
            lock_d  = 1'b1;
          end else begin
            good_d = good_q + 1'b1;
          end
        end else begin
          good_d = '0;
        end
      end
    end

    drop_d = drop_q;
    if (drop_hit && (drop_q != '1)) drop_d = drop_q + {{(DROP_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_COARSE;
      n_q       <= '0;
      drop_q    <= '0;
      good_q    <= '0;
      bad_q     <= '0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      lock_q    <= 1'b0;
      useen_q   <= 1'b0;
      dseen_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      n_q       <= n_d;
      drop_q    <= drop_d;
      good_q    <= good_d;
      bad_q     <= bad_d;
      up_q      <= up_d;
      dn_q      <= dn_d;
      lock_q    <= lock_d;
      useen_q   <= useen_d;
      dseen_q   <= dseen_d;
      started_q <= 1'b1;
    end
  end

  assign up_req_o = up_q;
  assign dn_req_o = dn_q;
  assign fine_o   = (phase_q == PH_FINE);
  assign locked_o = lock_q;
  assign n_o      = n_q;
  assign drop_o   = drop_q;

  assert_req_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));
  assert_locked_in_fine_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (phase_q == PH_FINE));
  assert_n_frozen_coarse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && phase_q == PH_COARSE) |=> n_q == $past(n_q));
  assert_n_moves_at_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !win_end_i) |=> n_q == $past(n_q));
  assert_drop_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> drop_q >= $past(drop_q));
endmodule

// File: rtl/abb_lock_ctrl.sv
`timescale 1ns/1ps
module abb_lock_ctrl #(
  parameter int R_W        = 8,
  parameter int N_W        = 8,
  parameter int CODE_W     = 6,
  parameter int ZERO_CODE  = 32,
  parameter int NMON       = 4,
  parameter int DROP_W     = 8,
  parameter int SYNC_STG   = 2,
  parameter int LOCK_WIN   = 4,
  parameter int UNLOCK_WIN = 4,
  parameter int LOCK_TOL   = 1,
  parameter int UNLOCK_TOL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_i,
  input  logic              osc_clk_i,
  input  logic [NMON-1:0]   mon_up_i,
  input  logic [NMON-1:0]   mon_dn_i,
  input  logic [R_W-1:0]    cfg_r_i,
  input  logic [N_W-1:0]    cfg_n_init_i,
  input  logic [N_W-1:0]    cfg_n_min_i,
  input  logic [N_W-1:0]    cfg_n_max_i,
  output logic              nw_inc_o,
  output logic              nw_dec_o,
  output logic              pw_inc_o,
  output logic              pw_dec_o,
  output logic [CODE_W-1:0] nw_code_o,
  output logic [CODE_W-1:0] pw_code_o,
  output logic              fine_o,
  output logic              locked_o,
  output logic [N_W-1:0]    n_cur_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int CNT_W = N_W + 1;

  logic              rst_i_n;
  logic [1:0]        raw_clk, rise;
  logic              win_end;
  logic [CNT_W-1:0]  win_cnt;
  logic              up_req, dn_req;
  logic [1:0]        inc_v, dec_v;
  logic [CODE_W-1:0] code_v [2];

  abb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign raw_clk = {osc_clk_i, ref_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    abb_edge_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_i_n), .async_i(raw_clk[g]), .rise_o(rise[g]));
  end

  abb_freq_meter #(.R_W(R_W), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_i_n),
    .ref_rise_i(rise[0]), .osc_rise_i(rise[1]), .cfg_r_i(cfg_r_i),
    .win_end_o(win_end), .win_cnt_o(win_cnt));

  abb_trim_ctrl #(
    .N_W(N_W), .CNT_W(CNT_W), .DROP_W(DROP_W),
    .LOCK_WIN(LOCK_WIN), .UNLOCK_WIN(UNLOCK_WIN),
    .LOCK_TOL(LOCK_TOL), .UNLOCK_TOL(UNLOCK_TOL)
  ) u_trim (
    .clk(clk), .rst_n(rst_i_n),
    .win_end_i(win_end), .win_cnt_i(win_cnt),
    .mon_up_i(|mon_up_i), .mon_dn_i(|mon_dn_i),
    .cfg_n_init_i(cfg_n_init_i), .cfg_n_min_i(cfg_n_min_i), .cfg_n_max_i(cfg_n_max_i),
    .up_req_o(up_req), .dn_req_o(dn_req),
    .fine_o(fine_o), .locked_o(locked_o), .n_o(n_cur_o), .drop_o(drop_cnt_o));

  for (genvar w = 0; w < 2; w++) begin : g_well
    abb_bias_code #(.CODE_W(CODE_W), .ZERO_CODE(ZERO_CODE)) u_code (
      .clk(clk), .rst_n(rst_i_n),
      .up_req_i(up_req), .dn_req_i(dn_req),
      .inc_o(inc_v[w]), .dec_o(dec_v[w]), .code_o(code_v[w]));
  end

  assign nw_inc_o  = inc_v[0];
  assign nw_dec_o  = dec_v[0];
  assign pw_inc_o  = inc_v[1];
  assign pw_dec_o  = dec_v[1];
  assign nw_code_o = code_v[0];
  assign pw_code_o = code_v[1];
endmodule

// File: tb/abb_lock_ctrl_tb.sv
`timescale 1ns/1ps
module abb_lock_ctrl_tb;
  localparam int WIN = 24;  // R=6 target periods of 4 clk cycles

  logic clk = 1'b0;
  logic rst_n;
  logic ref_clk, osc_clk;
  logic [3:0] mon_up, mon_dn;
  logic [7:0] cfg_r, cfg_n_init, cfg_n_min, cfg_n_max;
  logic nw_inc, nw_dec, pw_inc, pw_dec, fine, locked;
  logic [5:0] nw_code, pw_code;
  logic [7:0] n_cur, drop_cnt;

  int tests = 0, fails = 0;
  int osc_per = 0;
  int inc_cnt = 0, dec_cnt = 0, pair_err = 0;
  logic prev_pulse = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  abb_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .osc_clk_i(osc_clk),
    .mon_up_i(mon_up), .mon_dn_i(mon_dn), .cfg_r_i(cfg_r),
    .cfg_n_init_i(cfg_n_init), .cfg_n_min_i(cfg_n_min), .cfg_n_max_i(cfg_n_max),
    .nw_inc_o(nw_inc), .nw_dec_o(nw_dec), .pw_inc_o(pw_inc), .pw_dec_o(pw_dec),
    .nw_code_o(nw_code), .pw_code_o(pw_code), .fine_o(fine), .locked_o(locked),
    .n_cur_o(n_cur), .drop_cnt_o(drop_cnt));

  // clock models: target period 4 cycles, oscillator period osc_per cycles
  initial begin
    int rph = 0;
    int oph = 0;
    ref_clk = 1'b0;
    osc_clk = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      ref_clk = (rph < 2);
      rph = (rph + 1) % 4;
      if (osc_per == 0) begin
        osc_clk = 1'b0;
        oph = 0;
      end else begin
        if (oph >= osc_per) oph = 0;
        osc_clk = (oph < osc_per / 2) || (osc_per == 1);
        oph = oph + 1;
      end
    end
  end

  // pulse observer: both drivers together, one direction, one cycle (R3)
  always @(negedge clk) begin
    if (rst_n) begin
      if (nw_inc) inc_cnt++;
      if (nw_dec) dec_cnt++;
      if ((nw_inc != pw_inc) || (nw_dec != pw_dec) || (nw_inc && nw_dec) ||
          ((nw_inc || nw_dec) && prev_pulse))
        pair_err++;
      prev_pulse = nw_inc || nw_dec;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_mon(input logic up, input logic dn);
    @(negedge clk);
    mon_up = {1'b0, up, 2'b00};
    mon_dn = {dn, 3'b000};
    @(negedge clk);
    mon_up = '0;
    mon_dn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c0, ib, db;
    rst_n = 1'b0;
    mon_up = '0; mon_dn = '0;
    cfg_r = 8'd6; cfg_n_init = 8'd6; cfg_n_min = 8'd4; cfg_n_max = 8'd8;
    cyc(5);
    // R1: state under reset
    chk("R1 nw_code in reset", nw_code, 32);
    chk("R1 pw_code in reset", pw_code, 32);
    chk("R1 fine in reset", fine, 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(6);
    chk("R1 n after release", n_cur, 6);
    chk("R1 codes after release", nw_code + pw_code, 64);
    chk("R1 locked after release", locked, 0);
    chk("R1 drop after release", drop_cnt, 0);
    chk("R1 no pulses yet", inc_cnt + dec_cnt, 0);

    // R2/R4: too fast (8 edges vs N=6) -> decrements down to 0
    osc_per = 3;
    cyc(2 * WIN);
    c0 = nw_code; db = dec_cnt; ib = inc_cnt;
    pulse_mon(1'b1, 1'b0);           // R8: coarse, ignored
    cyc(2 * WIN);
    chk("R8 monitor ignored in coarse", n_cur, 6);
    cyc(50 * WIN);
    chk("R4 code floor", nw_code, 0);
    chk("R2 decrement count equals code travel", dec_cnt - db, c0);
    chk("R2 no increments when fast", inc_cnt - ib, 0);
    chk("R4 p-well floor", pw_code, 0);

    // R2/R3/R4: too slow (4 edges vs N=6)
    osc_per = 6;
    cyc(2 * WIN);
    c0 = nw_code; ib = inc_cnt;
    cyc(5 * WIN);
    chk("R3 five windows give five increments", inc_cnt - ib, 5);
    chk("R3 code step per increment", nw_code, c0 + 5);
    cyc(70 * WIN);
    chk("R4 code ceiling", nw_code, 63);
    chk("R4 suppressed beyond ceiling", inc_cnt - ib, 63 - c0);
    chk("R5 err 2 keeps coarse", fine, 0);

    // R5/R6/R2: exact match (6 edges)
    osc_per = 4;
    cyc(2 * WIN);
    chk("R5 not fine after two windows", fine, 0);
    ib = inc_cnt; db = dec_cnt; c0 = nw_code;
    cyc(4 * WIN + 10);
    chk("R5 fine after four good windows", fine, 1);
    chk("R6 locked on entry", locked, 1);
    chk("R2 no pulse when count equals N", (inc_cnt - ib) + (dec_cnt - db), 0);
    chk("R2 code held at match", nw_code, c0);

    // R9/R10/R11: monitor trimming in fine phase
    pulse_mon(1'b1, 1'b0); cyc(2 * WIN);
    chk("R9 up raises N", n_cur, 7);
    chk("R6 locked within one", locked, 1);
    pulse_mon(1'b0, 1'b1); cyc(2 * WIN);
    chk("R9 down lowers N", n_cur, 6);
    pulse_mon(1'b1, 1'b1); cyc(2 * WIN);
    chk("R10 up and down cancel", n_cur, 6);
    pulse_mon(1'b0, 1'b1); cyc(2 * WIN);
    pulse_mon(1'b0, 1'b1); cyc(2 * WIN);
    chk("R11 reach minimum", n_cur, 4);
    chk("R6 unlocked at error 2", locked, 0);
    chk("R7 error 2 stays fine", fine, 1);
    pulse_mon(1'b0, 1'b1); cyc(2 * WIN);
    chk("R11 held at minimum", n_cur, 4);
    chk("R11 drop counted", drop_cnt, 1);
    for (int k = 0; k < 4; k++) begin
      pulse_mon(1'b1, 1'b0); cyc(2 * WIN);
    end
    chk("R11 reach maximum", n_cur, 8);
    pulse_mon(1'b1, 1'b0); cyc(2 * WIN);
    chk("R11 held at maximum", n_cur, 8);
    chk("R11 drop counted again", drop_cnt, 2);

    // R7: far too slow (1 edge vs N=8)
    osc_per = 24;
    cyc(2 * WIN);
    chk("R7 still fine after two bad windows", fine, 1);
    cyc(4 * WIN + 10);
    chk("R7 back to coarse", fine, 0);
    chk("R6 locked cleared with phase", locked, 0);
    pulse_mon(1'b0, 1'b1); cyc(2 * WIN);
    chk("R8 monitor ignored after exit", n_cur, 8);
    chk("R11 drop counter sticky", drop_cnt, 2);

    chk("R3 driver pulses paired and single", pair_err, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule